// File: doc/BRIEF.md
# Same-Cycle Visible Register File

This block is the general-purpose register store of a five-stage pipelined processor. It holds 32 words of 32 bits and serves two operand read ports and one write port from the write-back stage. A value that write-back delivers must reach an instruction reading the same register in that same cycle. So the file does not act like a plain edge-triggered array. The array itself updates on the rising edge. Each operand port also compares its address with the live write address and, on a match, returns the incoming write data combinationally.

Register 0 is hard-wired to zero. A synchronous, active-low reset clears the whole store. A third, diagnostic read port shows the contents as they are held. It has no bypass, so it exposes exactly what the array has captured. Operand forwarding from other stages and hazard detection are not part of this block.

Top module: `wbr_regfile`

## Requirements
- R1: The store has 32 entries of 32 bits, selected by 5-bit addresses. When `wr_en` is high on a rising edge, the entry at `wr_addr` takes `wr_data`, and the new value is readable from the next cycle on.
- R2: `rd_a_data` and `rd_b_data` follow their addresses combinationally, within the cycle, and show the stored entry when no write to that entry is live.
- R3: While a write to entry N (N ≠ 0) is live, an operand port addressing N returns `wr_data` in that same cycle, before the edge that stores it.
- R4: When both operand ports address the entry being written, both return the write data in that cycle.
- R5: Address 0 reads as zero on all three read ports at all times. A write to address 0 changes nothing and is never forwarded.
- R6: While `rst_n` is low at a rising edge, every entry is cleared to zero. A write presented during reset is neither stored nor forwarded.
- R7: `dbg_data` shows the stored entry at `dbg_addr` with no bypass. During a write cycle it still shows the old value, and it shows the new one from the next cycle.
- R8: With `wr_en` low, no entry changes, whatever `wr_addr` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request from write-back |
| wr_addr | input | 5 | Entry to write |
| wr_data | input | 32 | Value to write |
| rd_a_addr | input | 5 | Operand port A address |
| rd_a_data | output | 32 | Operand port A data, write-bypassed |
| rd_b_addr | input | 5 | Operand port B address |
| rd_b_data | output | 32 | Operand port B data, write-bypassed |
| dbg_addr | input | 5 | Diagnostic port address |
| dbg_data | output | 32 | Diagnostic port data, stored value only |

## Verification
The bench checks operand reads in the cycle a write is presented. A file that relies only on the edge would return stale data there. It writes to register 0 while reading it, which catches a bypass that forwards zero-register writes or a store that keeps them. It drives writes while reset is low, to catch a forward or a capture that ignores reset. It also reads the diagnostic port during write cycles, which shows whether that port wrongly bypasses or whether a write lands a cycle late or early.

// File: rtl/wbr_regfile_pkg.sv
package wbr_regfile_pkg;
    localparam int unsigned RF_DATA_W = 32;
    localparam int unsigned RF_DEPTH  = 32;
    localparam int unsigned RF_ADDR_W = $clog2(RF_DEPTH);
    localparam int unsigned RF_RPORTS = 3;   // two operand ports plus diagnostic
endpackage

// File: rtl/wbr_regfile_store.sv
module wbr_regfile_store #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 32,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_live,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [DEPTH*DATA_W-1:0] regs_flat
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] regs;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_live) begin
            st_d.regs[wr_addr] = wr_data;
        end
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign regs_flat = st_q.regs;
endmodule

// File: rtl/wbr_regfile_rdport.sv
module wbr_regfile_rdport #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 32,
    parameter bit          BYPASS = 1'b1,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic [DEPTH*DATA_W-1:0] regs_flat,
    input  logic                    wr_live,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data
);
    logic [DATA_W-1:0] stored;
    logic              hit;

    assign stored = regs_flat[rd_addr*DATA_W +: DATA_W];

    generate
        if (BYPASS) begin : g_bypass
            assign hit = wr_live && (wr_addr == rd_addr);
        end else begin : g_plain
            assign hit = 1'b0;
        end
    endgenerate

    always_comb begin
        if (rd_addr == '0) begin
            rd_data = '0;
        end else if (hit) begin
            rd_data = wr_data;
        end else begin
            rd_data = stored;
        end
    end
endmodule

// File: rtl/wbr_regfile.sv
module wbr_regfile
    import wbr_regfile_pkg::*;
#(
    parameter int unsigned DATA_W = RF_DATA_W,
    parameter int unsigned DEPTH  = RF_DEPTH,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic [ADDR_W-1:0] dbg_addr,
    output logic [DATA_W-1:0] dbg_data
);
    localparam int unsigned NPORT = RF_RPORTS;

    logic                    wr_live;
    logic [DEPTH*DATA_W-1:0] regs_flat;
    logic [ADDR_W-1:0]       port_addr [NPORT];
    logic [DATA_W-1:0]       port_data [NPORT];

    // a write counts only out of reset and away from the zero register
    assign wr_live = wr_en && rst_n && (wr_addr != '0);

    wbr_regfile_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_live  (wr_live),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .regs_flat(regs_flat)
    );

    assign port_addr[0] = rd_a_addr;
    assign port_addr[1] = rd_b_addr;
    assign port_addr[2] = dbg_addr;

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            wbr_regfile_rdport #(
                .DATA_W(DATA_W),
                .DEPTH (DEPTH),
                .BYPASS(p < 2)
            ) u_rd (
                .regs_flat(regs_flat),
                .wr_live  (wr_live),
                .wr_addr  (wr_addr),
                .wr_data  (wr_data),
                .rd_addr  (port_addr[p]),
                .rd_data  (port_data[p])
            );
        end
    endgenerate

    assign rd_a_data = port_data[0];
    assign rd_b_data = port_data[1];
    assign dbg_data  = port_data[2];
endmodule

// File: rtl/wbr_regfile_chk.sv
module wbr_regfile_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 32,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_a_addr,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [ADDR_W-1:0] rd_b_addr,
    input logic [DATA_W-1:0] rd_b_data,
    input logic [ADDR_W-1:0] dbg_addr,
    input logic [DATA_W-1:0] dbg_data
);
    logic was_rst = 1'b0;
    logic live_q  = 1'b0;
    always_ff @(posedge clk) begin
        was_rst <= !rst_n;
        live_q  <= rst_n && wr_en && (wr_addr != '0);
    end

    AST_ZERO_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == '0) |-> (rd_a_data == '0)); // R5
    AST_ZERO_DBG: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_addr == '0) |-> (dbg_data == '0)); // R5
    AST_BYPASS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0 && rd_b_addr == wr_addr) |-> (rd_b_data == wr_data)); // R3
    AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == rd_b_addr) |-> (rd_a_data == rd_b_data)); // R4
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && dbg_addr == $past(wr_addr)) |-> (dbg_data == $past(wr_data))); // R1
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> (dbg_data == '0)); // R6
endmodule

bind wbr_regfile wbr_regfile_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/wbr_regfile_bench.sv
`timescale 1ns/1ps
module wbr_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0, rd_a_addr = '0, rd_b_addr = '0, dbg_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_a_data, rd_b_data, dbg_data;

    int unsigned n_tests = 0, n_fail = 0;
    logic [31:0] mdl [32];

    always #2.5 clk = ~clk;

    wbr_regfile u_wbr_regfile (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .dbg_addr(dbg_addr), .dbg_data(dbg_data)
    );

    function automatic logic [31:0] exp_op(input logic [4:0] a);
        if (a == 0) return '0;
        if (rst_n && wr_en && wr_addr == a) return wr_data;
        return mdl[a];
    endfunction

    function automatic logic [31:0] exp_dbg(input logic [4:0] a);
        return (a == 0) ? '0 : mdl[a];
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // drive one cycle, check all read ports mid-cycle, then follow the edge in the model
    task automatic step(input logic rst_v, input logic we, input logic [4:0] wa, input logic [31:0] wd,
                        input logic [4:0] ra, input logic [4:0] rb, input logic [4:0] da,
                        input string tag, input bit do_chk);
        @(negedge clk);
        rst_n = rst_v; wr_en = we; wr_addr = wa; wr_data = wd;
        rd_a_addr = ra; rd_b_addr = rb; dbg_addr = da;
        #1;
        if (do_chk) begin
            check(tag, "port A", rd_a_data, exp_op(ra));
            check(tag, "port B", rd_b_data, exp_op(rb));
            check(tag, "debug", dbg_data, exp_dbg(da));
        end
        @(posedge clk);
        if (!rst_v) begin
            for (int i = 0; i < 32; i++) mdl[i] = '0;
        end else if (we && wa != 0) begin
            mdl[wa] = wd;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        // first reset edge with outputs unchecked (store holds unknowns before it)
        step(1'b0, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0, 5'd0, "R6", 1'b0);
        // R6: every entry reads zero after reset
        for (int i = 0; i < 32; i++) step(1'b1, 1'b0, 5'd0, 32'h0, i[4:0], 5'(31 - i), i[4:0], "R6", 1'b1);
        // R1: write the top and bottom usable entries, read back next cycle
        step(1'b1, 1'b1, 5'd31, 32'hDEAD_BEEF, 5'd2, 5'd3, 5'd4, "R1", 1'b1);
        step(1'b1, 1'b1, 5'd1,  32'h1234_5678, 5'd31, 5'd2, 5'd31, "R1", 1'b1);
        step(1'b1, 1'b0, 5'd0,  32'h0, 5'd1, 5'd31, 5'd1, "R1", 1'b1);
        // R3: read in the same cycle as the write
        step(1'b1, 1'b1, 5'd7, 32'hA5A5_0007, 5'd7, 5'd31, 5'd6, "R3", 1'b1);
        step(1'b1, 1'b1, 5'd7, 32'h0BAD_F00D, 5'd1, 5'd7, 5'd7, "R3", 1'b1);
        // R4: both operand ports on the entry being written
        step(1'b1, 1'b1, 5'd12, 32'hCAFE_0012, 5'd12, 5'd12, 5'd0, "R4", 1'b1);
        // R7: debug shows old value during the write, new one afterwards
        step(1'b1, 1'b1, 5'd12, 32'h5555_AAAA, 5'd3, 5'd4, 5'd12, "R7", 1'b1);
        step(1'b1, 1'b0, 5'd12, 32'h0, 5'd3, 5'd4, 5'd12, "R7", 1'b1);
        // R5: write to zero register while reading it on every port
        step(1'b1, 1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0, 5'd0, "R5", 1'b1);
        step(1'b1, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0, 5'd0, "R5", 1'b1);
        // R8: disabled write with live address and data
        step(1'b1, 1'b0, 5'd31, 32'h0000_1111, 5'd31, 5'd31, 5'd31, "R8", 1'b1);
        step(1'b1, 1'b0, 5'd0, 32'h0, 5'd31, 5'd1, 5'd31, "R8", 1'b1);
        // R6: a write during reset is neither forwarded nor kept
        step(1'b0, 1'b1, 5'd9, 32'h9999_9999, 5'd9, 5'd9, 5'd9, "R6", 1'b0);
        n_tests++;
        if (rd_a_data !== 32'h0) begin
            n_fail++;
            $display("FAIL R6 forward during reset: actual %h expected %h", rd_a_data, 32'h0);
        end
        for (int i = 0; i < 32; i++) step(1'b1, 1'b0, 5'd0, 32'h0, 5'd9, i[4:0], i[4:0], "R6", 1'b1);
        // R2: random traffic biased toward address collisions
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] wa, ra, rb;
            wa = 5'($urandom);
            ra = ($urandom % 3 == 0) ? wa : 5'($urandom);
            rb = ($urandom % 4 == 0) ? ra : 5'($urandom % 8);
            step(($urandom % 97) != 0, ($urandom % 4) != 0, wa, $urandom, ra, rb,
                 ($urandom % 2 == 0) ? wa : 5'($urandom), "R2", 1'b1);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule